// File: doc/BRIEF.md
# Masked-Write Clock Gate and Reset Bank

This block is a register bank that owns the per-module clock enables, the per-module reset lines and the bus-stop request lines of a subsystem. Software reaches it through a simple 32-bit word-addressed register port. Every control register takes a masked write. The low half of the write word carries the new values. The high half carries one enable per bit, so a single write changes exactly the chosen bits, and no read-modify-write sequence is needed.

Each clock bank and each reset bank has a matching read-only monitor bank. The monitor shows the state of the controlled line after it has passed through a resynchronising chain of configurable depth. Software writes a control register and then polls the matching monitor until the new state shows. The gating cells, the PLLs and the interconnect lie outside the block.

Top module: `cgr_bank`

## Requirements
- R1: After a synchronous reset, every clock enable output is 0, every module reset output is 1 (reset in effect) and every bus-stop output is 1. Clock-control registers and reset-control registers read 0x0000, bus-stop registers read 0xFFFF, clock monitors read 0x0000 and reset monitors read 0xFFFF.
- R2: A write to a control register updates bit i (i in 0..15) to write-data bit i only when write-data bit i+16 is 1. Every bit whose enable is 0 keeps its old value.
- R3: Clock-control register n sits at byte offset 0x600+4n. Its bit i drives clk_en_o[16n+i], where 1 runs the clock. The output changes at the same clock edge that samples the write.
- R4: Reset-control register n sits at 0x900+4n. A stored 0 drives mod_rst_o[16n+i] to 1 (reset asserted). A stored 1 drives it to 0 (released). It updates at the write edge.
- R5: Bus-stop group m (m starting at 1) sits at 0xD00+4(m-1) and drives bus_stop_o[16(m-1)+i]. A stored 1 requests a stop of that bus path.
- R6: Clock monitor n at 0x800+4n returns the clock enables of register n delayed by SYNC_STAGES cycles. A read sampled fewer than SYNC_STAGES+1 edges after the write edge returns the old value. A read sampled SYNC_STAGES+1 or more edges after it returns the new value.
- R7: Reset monitor n at 0xA00+4n returns 1 for each reset in effect and 0 for each released one, with the same latency as R6.
- R8: A read sampled at a clock edge puts the addressed register on bus_rdata after that edge. Bits 31:16 are 0. bus_rdata holds its value when no read is made.
- R9: Reads of unmapped offsets return 0. Unmapped offsets are those outside the windows above, those beyond the configured count of a window, and those with byte-address bits 1:0 not equal to 00. Writes to unmapped offsets and to monitor registers change no output and no register.
- R10: Register n of each bank maps only to output bits 16n..16n+15. A write to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, sampled at each rising edge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| clk_en_o | output | 16*NCLK_REGS | Module clock enables |
| mod_rst_o | output | 16*NRST_REGS | Module resets, 1 = in reset |
| bus_stop_o | output | 16*NSTOP_GRPS | Bus-stop requests, 1 = stop |

## Verification
Control outputs are due at the falling edge that follows the write edge. The bench compares them there against a masked-write model after every write. Read data is due one edge after the read request, so each read task samples it at the next falling edge. A monitor is due SYNC_STAGES+1 edges after the write. The bench issues back-to-back monitor reads starting one edge after a write and expects the old value for the first SYNC_STAGES reads and the new value after that. Random writes wait SYNC_STAGES+1 cycles before a monitor read, so that read is compared only against the settled value.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  localparam int REG_BITS = 16;
  localparam int BUS_W    = 2 * REG_BITS;
  localparam int ADDR_W   = 12;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int IDX_W    = 6;

  // word-address bases of each window (byte offset / 4)
  localparam int CLK_CTRL_WBASE = 'h600 / 4;
  localparam int CLK_MON_WBASE  = 'h800 / 4;
  localparam int RST_CTRL_WBASE = 'h900 / 4;
  localparam int RST_MON_WBASE  = 'hA00 / 4;
  localparam int STOP_WBASE     = 'hD00 / 4;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CLK_CTRL,
    RG_CLK_MON,
    RG_RST_CTRL,
    RG_RST_MON,
    RG_STOP
  } region_e;

  function automatic logic in_window(input logic [WORD_W-1:0] w, input int base, input int count);
    return (int'(w) >= base) && (int'(w) < base + count);
  endfunction

endpackage

// File: rtl/cgr_decode.sv
module cgr_decode import cgr_pkg::*; #(
  parameter int NCLK  = 4,
  parameter int NRST  = 3,
  parameter int NSTOP = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (aligned) begin
      if (in_window(word, CLK_CTRL_WBASE, NCLK)) begin
        region = RG_CLK_CTRL;
        idx    = IDX_W'(int'(word) - CLK_CTRL_WBASE);
      end else if (in_window(word, CLK_MON_WBASE, NCLK)) begin
        region = RG_CLK_MON;
        idx    = IDX_W'(int'(word) - CLK_MON_WBASE);
      end else if (in_window(word, RST_CTRL_WBASE, NRST)) begin
        region = RG_RST_CTRL;
        idx    = IDX_W'(int'(word) - RST_CTRL_WBASE);
      end else if (in_window(word, RST_MON_WBASE, NRST)) begin
        region = RG_RST_MON;
        idx    = IDX_W'(int'(word) - RST_MON_WBASE);
      end else if (in_window(word, STOP_WBASE, NSTOP)) begin
        region = RG_STOP;
        idx    = IDX_W'(int'(word) - STOP_WBASE);
      end
    end
  end

endmodule

// File: rtl/cgr_mask_reg.sv
module cgr_mask_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);

  logic [W-1:0] en;
  logic [W-1:0] val;

  assign en  = wdata[2*W-1:W];
  assign val = wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= (q & ~en) | (val & en);
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q ^ $past(q)) & ~$past(en)) == '0);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q ^ $past(val)) & $past(en)) == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/cgr_sync.sv
module cgr_sync #(
  parameter int           W       = 16,
  parameter int           STAGES  = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  // checker: edges since reset, saturating at STAGES
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)                     age <= '0;
    else if (age != 3'(STAGES))  age <= age + 3'd1;
  end

  // R6 R7
  sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 3'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/cgr_bank.sv
module cgr_bank import cgr_pkg::*; #(
  parameter int NCLK_REGS   = 4,
  parameter int NRST_REGS   = 3,
  parameter int NSTOP_GRPS  = 2,
  parameter int SYNC_STAGES = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [BUS_W-1:0]               bus_wdata,
  output logic [BUS_W-1:0]               bus_rdata,
  output logic [NCLK_REGS*REG_BITS-1:0]  clk_en_o,
  output logic [NRST_REGS*REG_BITS-1:0]  mod_rst_o,
  output logic [NSTOP_GRPS*REG_BITS-1:0] bus_stop_o
);

  localparam int CLK_W  = NCLK_REGS * REG_BITS;
  localparam int RST_W  = NRST_REGS * REG_BITS;
  localparam int STOP_W = NSTOP_GRPS * REG_BITS;

  region_e             region;
  logic [IDX_W-1:0]    idx;
  logic                wr_hit;
  logic                rd_hit;
  logic [CLK_W-1:0]    clk_q;
  logic [RST_W-1:0]    rst_q;
  logic [STOP_W-1:0]   stop_q;
  logic [CLK_W-1:0]    clk_mon;
  logic [RST_W-1:0]    rst_mon;
  logic [REG_BITS-1:0] rd_word;

  cgr_decode #(.NCLK(NCLK_REGS), .NRST(NRST_REGS), .NSTOP(NSTOP_GRPS)) u_decode (
    .addr   (bus_addr),
    .region (region),
    .idx    (idx)
  );

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  for (genvar g = 0; g < NCLK_REGS; g++) begin : g_clk
    cgr_mask_reg #(.W(REG_BITS), .RST_VAL('0)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hit && region == RG_CLK_CTRL && idx == IDX_W'(g)),
      .wdata (bus_wdata),
      .q     (clk_q[g*REG_BITS +: REG_BITS])
    );
  end

  for (genvar g = 0; g < NRST_REGS; g++) begin : g_rst
    cgr_mask_reg #(.W(REG_BITS), .RST_VAL('0)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hit && region == RG_RST_CTRL && idx == IDX_W'(g)),
      .wdata (bus_wdata),
      .q     (rst_q[g*REG_BITS +: REG_BITS])
    );
  end

  for (genvar g = 0; g < NSTOP_GRPS; g++) begin : g_stop
    cgr_mask_reg #(.W(REG_BITS), .RST_VAL('1)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hit && region == RG_STOP && idx == IDX_W'(g)),
      .wdata (bus_wdata),
      .q     (stop_q[g*REG_BITS +: REG_BITS])
    );
  end

  assign clk_en_o   = clk_q;
  assign mod_rst_o  = ~rst_q;
  assign bus_stop_o = stop_q;

  cgr_sync #(.W(CLK_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_clk_mon (
    .clk (clk),
    .rst (rst),
    .d   (clk_en_o),
    .q   (clk_mon)
  );

  cgr_sync #(.W(RST_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_rst_mon (
    .clk (clk),
    .rst (rst),
    .d   (mod_rst_o),
    .q   (rst_mon)
  );

  always_comb begin
    case (region)
      RG_CLK_CTRL: rd_word = clk_q[idx*REG_BITS +: REG_BITS];
      RG_CLK_MON:  rd_word = clk_mon[idx*REG_BITS +: REG_BITS];
      RG_RST_CTRL: rd_word = rst_q[idx*REG_BITS +: REG_BITS];
      RG_RST_MON:  rd_word = rst_mon[idx*REG_BITS +: REG_BITS];
      RG_STOP:     rd_word = stop_q[idx*REG_BITS +: REG_BITS];
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= {{(BUS_W-REG_BITS){1'b0}}, rd_word};
  end

  // R9
  nomap_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (region == RG_NONE || region == RG_CLK_MON || region == RG_RST_MON))
      |=> ($stable(clk_en_o) && $stable(mod_rst_o) && $stable(bus_stop_o)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata));

endmodule

// File: tb/test_cgr_bank.sv
module test_cgr_bank;

  localparam int NC = 4;
  localparam int NR = 3;
  localparam int NS = 2;
  localparam int SS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC*16-1:0] clk_en_o;
  logic [NR*16-1:0] mod_rst_o;
  logic [NS*16-1:0] bus_stop_o;

  always #10 clk = ~clk;

  cgr_bank #(.NCLK_REGS(NC), .NRST_REGS(NR), .NSTOP_GRPS(NS), .SYNC_STAGES(SS)) i_cgr_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en_o(clk_en_o),
    .mod_rst_o(mod_rst_o), .bus_stop_o(bus_stop_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [15:0] m_clk [NC];
  logic [15:0] m_rst [NR];
  logic [15:0] m_stop [NS];

  function automatic logic [15:0] mw(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic int win(input logic [11:0] a, input int base, input int n);
    if (a[1:0] != 2'b00) return -1;
    if (int'(a) >= base && int'(a) < base + 4*n) return (int'(a) - base) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int k;
    k = win(a, 'h600, NC); if (k >= 0) return {16'h0, m_clk[k]};
    k = win(a, 'h800, NC); if (k >= 0) return {16'h0, m_clk[k]};
    k = win(a, 'h900, NR); if (k >= 0) return {16'h0, m_rst[k]};
    k = win(a, 'hA00, NR); if (k >= 0) return {16'h0, ~m_rst[k]};
    k = win(a, 'hD00, NS); if (k >= 0) return {16'h0, m_stop[k]};
    return 32'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int k;
    k = win(a, 'h600, NC); if (k >= 0) m_clk[k] = mw(m_clk[k], d);
    k = win(a, 'h900, NR); if (k >= 0) m_rst[k] = mw(m_rst[k], d);
    k = win(a, 'hD00, NS); if (k >= 0) m_stop[k] = mw(m_stop[k], d);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic check_ports(input string tag);
    for (int i = 0; i < NC; i++) check({tag, " R3 clk_en"}, {16'h0, clk_en_o[16*i +: 16]}, {16'h0, m_clk[i]});
    for (int i = 0; i < NR; i++) check({tag, " R4 mod_rst"}, {16'h0, mod_rst_o[16*i +: 16]}, {16'h0, ~m_rst[i]});
    for (int i = 0; i < NS; i++) check({tag, " R5 bus_stop"}, {16'h0, bus_stop_o[16*i +: 16]}, {16'h0, m_stop[i]});
  endtask

  // back-to-back reads after a write; new value due from read SS+1 on
  task automatic burst(input string req, input logic [11:0] a, input logic [15:0] oldv, input logic [15:0] newv);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    for (int i = 1; i <= SS + 2; i++) begin
      @(negedge clk);
      check(req, bus_rdata, {16'h0, (i >= SS + 1) ? newv : oldv});
    end
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = $urandom(32'h0C6B_5A11);
    for (int i = 0; i < NC; i++) m_clk[i] = 16'h0000;
    for (int i = 0; i < NR; i++) m_rst[i] = 16'h0000;
    for (int i = 0; i < NS; i++) m_stop[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_ports("R1");
    for (int i = 0; i < NC; i++) rd_check("R1 clk ctrl", 12'(('h600) + 4*i));
    for (int i = 0; i < NC; i++) rd_check("R1 clk mon", 12'(('h800) + 4*i));
    for (int i = 0; i < NR; i++) rd_check("R1 rst ctrl", 12'(('h900) + 4*i));
    for (int i = 0; i < NR; i++) rd_check("R1 rst mon", 12'(('hA00) + 4*i));
    for (int i = 0; i < NS; i++) rd_check("R1 stop", 12'(('hD00) + 4*i));

    // R2 masked writes, R10 only register 1 moves
    wr(12'h604, 32'hFFFF_00A5); check_ports("R2 full");
    wr(12'h604, 32'h0F00_FFFF); check_ports("R2 part");
    rd(12'h604, d); check("R2 partial mask", d, 32'h0000_0FA5);
    wr(12'h604, 32'h0000_FFFF); check_ports("R2 none");
    rd(12'h604, d); check("R2 zero mask", d, 32'h0000_0FA5);
    rd_check("R10 neighbour", 12'h600);

    // R6 clock monitor latency
    wr(12'h608, 32'h0001_0001);
    burst("R6 clk mon latency", 12'h808, 16'h0000, 16'h0001);

    // R7 reset monitor latency, R4 release and re-assert
    wr(12'h900, 32'h0003_0003); check_ports("R4 release");
    burst("R7 rst mon latency", 12'hA00, 16'hFFFF, 16'hFFFC);
    wr(12'h900, 32'h0001_0000); check_ports("R4 assert");
    burst("R7 rst mon reassert", 12'hA00, 16'hFFFC, 16'hFFFD);

    // R5 stop group 2
    wr(12'hD04, 32'h00FF_0000); check_ports("R5 grp2");
    rd(12'hD04, d); check("R5 grp2 read", d, 32'h0000_FF00);

    // R8 upper bits zero
    wr(12'h60C, 32'hFFFF_FFFF);
    rd(12'h60C, d); check("R8 upper zero", d, 32'h0000_FFFF);

    // R9 unmapped and monitor writes ignored
    wr(12'h610, 32'hFFFF_FFFF); check_ports("R9 past end");
    wr(12'h800, 32'hFFFF_FFFF); check_ports("R9 mon write");
    wr(12'h601, 32'hFFFF_0000); check_ports("R9 unaligned");
    wr(12'h000, 32'hFFFF_FFFF); check_ports("R9 low");
    repeat (SS + 1) @(negedge clk);
    rd_check("R9 mon unchanged", 12'h800);
    rd(12'h610, d); check("R9 read past end", d, 32'h0);
    rd(12'h601, d); check("R9 read unaligned", d, 32'h0);
    rd(12'hA0C, d); check("R9 read rst mon past end", d, 32'h0);

    // random traffic
    for (int it = 0; it < 200; it++) begin
      logic [11:0] a;
      logic [31:0] w;
      int kind;
      kind = int'($urandom % 7);
      case (kind)
        0: a = 12'('h600 + 4 * int'($urandom % (NC + 1)));
        1: a = 12'('h800 + 4 * int'($urandom % (NC + 1)));
        2: a = 12'('h900 + 4 * int'($urandom % (NR + 1)));
        3: a = 12'('hA00 + 4 * int'($urandom % (NR + 1)));
        4: a = 12'('hD00 + 4 * int'($urandom % (NS + 1)));
        5: a = 12'($urandom) & 12'hFFC;
        default: a = 12'('h600 + 4 * int'($urandom % NC) + 1 + int'($urandom % 3));
      endcase
      w = $urandom;
      wr(a, w);
      check_ports("R2 R10 random");
      repeat (SS + 1) @(negedge clk);
      rd_check("R8 R9 random readback", a);
      if (kind == 0) rd_check("R6 random settled", a + 12'h200);
      if (kind == 2) rd_check("R7 random settled", a + 12'h100);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule